// File: doc/BRIEF.md
# I2C Master Primitive Command Engine

This block is a single-master I2C engine that executes one bus primitive per host command. The host does not hand over a whole addressed transfer. It builds each transaction from separate steps: a start condition, a byte write, a byte read that ends in ACK or NACK, and a stop condition. Address bytes and the read/write flag are sent by the host as ordinary write bytes.

The two bus wires are open-drain. The engine never drives a line high. It asserts an output enable only to pull a line low, and a released line is pulled high outside the block. The engine reads SDA through a separate input. Every bus phase is timed by a down-counter running on the system clock. A short phase (half a bit) lasts `HALF_CLKS` clocks, and a long phase (start and stop setup and hold) lasts twice that.

The host offers a command with a valid/ready handshake. When the command has finished, the engine pulses `done` for one cycle and presents the results on `rdata` and `ack_n`. A `bus_busy` flag shows that the bus is owned, from an accepted start until a stop has completed.

Top module: `i2c_prim_master`

## Requirements
- R1: After reset both output enables are 0 (lines released; an enable of 1 pulls its line low), `cmd_ready` is 1, and `done` and `bus_busy` are 0.
- R2: Command codes are 0 = start, 1 = stop, 2 = write byte, 3 = read byte then ACK, 4 = read byte then NACK. Codes 5 to 7 are ignored: they are not accepted, leave both lines unchanged and produce no `done`.
- R3: Start drives, with H = `HALF_CLKS`, SCL high and SDA high for 2H clocks, then SCL high and SDA low for 2H, then both low for 2H.
- R4: Stop drives both lines low for H, then SCL high and SDA low for 2H, then both high (released) for 2H.
- R5: Write byte sends bit 7 first. Each bit is held for H clocks with SCL low and then for H clocks with SCL high. SDA changes only while SCL is low.
- R6: After the eighth bit of a write, SDA is released for a ninth H-low/H-high clock, followed by an H-clock SCL-low tail. `ack_n` is the SDA level sampled in the last cycle of the ninth high phase (0 = ACK, 1 = NACK). `rdata` returns the byte seen on the bus.
- R7: A read releases SDA for eight clocks with the same timing. Before each sample it shifts the accumulated byte left and places the sampled SDA level into bit 0, so `rdata` holds the first bit received in bit 7.
- R8: After a read, the ninth clock drives SDA low (code 3) or leaves it released (code 4). SDA keeps that level through the SCL-low tail and is released when the command completes. `ack_n` reports that level.
- R9: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1 and the code is known. `cmd_ready` is 0 from then until completion, and commands presented meanwhile are dropped.
- R10: `done` is a single-cycle pulse arriving 6H (start), 5H (stop) or 19H (byte) clocks after the accepting edge, with `cmd_ready` already 1. Start and stop leave `rdata` and `ack_n` unchanged.
- R11: `bus_busy` is set by the accepting edge of a start and cleared by the completion of a stop. A repeated start keeps it set.
- R12: While idle, both lines hold the levels left by the last command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_code | input | 3 | Command code (see R2) |
| cmd_wdata | input | 8 | Byte for a write command |
| cmd_ready | output | 1 | Engine idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte seen on the bus by the last byte command |
| ack_n | output | 1 | Acknowledge level of the last byte command |
| bus_busy | output | 1 | Bus owned between start and stop |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The assertions assume that `sda_in` stays steady across each SCL high phase and that no other device drives SCL. The SDA-hold property also assumes that the host issues byte commands only after a start, with SCL already low. The bench keeps within these limits. Its slave model changes its SDA drive half a clock after an SCL fall, and every byte sequence it runs follows a start or another byte. A separate test holds a stop code on the command inputs while a write is running, to show that such commands are dropped.

// File: rtl/i2c_prim_pkg.sv
package i2c_prim_pkg;

    localparam int BYTE_BITS = 8;
    localparam int ACK_SLOT  = BYTE_BITS;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_STOP    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_RD_ACK  = 3'd3,
        OP_RD_NACK = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_STOP,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_TAIL
    } state_e;

    // logical line levels; 1 = released (pulled high)
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic op_is_byte(input logic [2:0] code);
        return (code == OP_WRITE) || (code == OP_RD_ACK) || (code == OP_RD_NACK);
    endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int HALF_CLKS = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic long_sel,
    output logic expire
);
    localparam int LONG_CLKS = 2 * HALF_CLKS;
    localparam int CW        = $clog2(LONG_CLKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= long_sel ? CW'(LONG_CLKS - 1) : CW'(HALF_CLKS - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end
endmodule

// File: rtl/i2c_prim_master.sv
module i2c_prim_master
    import i2c_prim_pkg::*;
#(
    parameter int HALF_CLKS = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic [7:0] cmd_wdata,
    output logic       cmd_ready,
    output logic       done,
    output logic [7:0] rdata,
    output logic       ack_n,
    output logic       bus_busy,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    localparam int IDX_W = $clog2(ACK_SLOT + 1);

    state_e            state;
    lines_t            lines;
    logic [1:0]        step;
    logic [IDX_W-1:0]  bit_idx;
    logic              is_rd;
    logic              ack_lvl;
    logic              ack_hold;
    logic              in_byte;

    logic              accept;
    logic              tmr_load, tmr_long, tmr_exp;
    logic              sh_load, sh_shift;
    logic [7:0]        sh_val, sh_q;
    logic              advance;

    assign accept  = (state == ST_IDLE) && cmd_valid && op_known(cmd_code);
    assign advance = (state != ST_IDLE) && tmr_exp;
    assign in_byte = (state == ST_BIT_LO) || (state == ST_BIT_HI) || (state == ST_TAIL);
    assign sh_val  = (op_e'(cmd_code) == OP_WRITE) ? cmd_wdata : 8'hFF;

    always_comb begin
        tmr_load = 1'b0;
        tmr_long = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_long = (op_e'(cmd_code) == OP_START);
            sh_load  = op_is_byte(cmd_code);
        end else if (advance) begin
            case (state)
                ST_START, ST_STOP: begin
                    tmr_load = (step != 2'd2);
                    tmr_long = 1'b1;
                end
                ST_BIT_LO: tmr_load = 1'b1;
                ST_BIT_HI: begin
                    tmr_load = 1'b1;
                    sh_shift = (bit_idx < IDX_W'(ACK_SLOT));
                end
                default: ;
            endcase
        end
    end

    i2c_phase_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .long_sel (tmr_long),
        .expire   (tmr_exp)
    );

    i2c_byte_shift #(.W(BYTE_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .sin      (sda_in),
        .q        (sh_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            lines    <= '{scl: 1'b1, sda: 1'b1};
            step     <= '0;
            bit_idx  <= '0;
            is_rd    <= 1'b0;
            ack_lvl  <= 1'b1;
            ack_hold <= 1'b1;
            done     <= 1'b0;
            rdata    <= '0;
            ack_n    <= 1'b1;
            bus_busy <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                step <= '0;
                case (op_e'(cmd_code))
                    OP_START: begin
                        state    <= ST_START;
                        lines    <= '{scl: 1'b1, sda: 1'b1};
                        bus_busy <= 1'b1;
                    end
                    OP_STOP: begin
                        state <= ST_STOP;
                        lines <= '{scl: 1'b0, sda: 1'b0};
                    end
                    default: begin
                        state   <= ST_BIT_LO;
                        bit_idx <= '0;
                        is_rd   <= (op_e'(cmd_code) != OP_WRITE);
                        ack_lvl <= (op_e'(cmd_code) == OP_RD_NACK);
                        lines   <= '{scl: 1'b0,
                                     sda: (op_e'(cmd_code) == OP_WRITE) ? cmd_wdata[7] : 1'b1};
                    end
                endcase
            end else if (advance) begin
                case (state)
                    ST_START: begin
                        step <= step + 1'b1;
                        if (step == 2'd0) begin
                            lines.sda <= 1'b0;
                        end else if (step == 2'd1) begin
                            lines.scl <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end
                    ST_STOP: begin
                        step <= step + 1'b1;
                        if (step == 2'd0) begin
                            lines.scl <= 1'b1;
                        end else if (step == 2'd1) begin
                            lines.sda <= 1'b1;
                        end else begin
                            state    <= ST_IDLE;
                            done     <= 1'b1;
                            bus_busy <= 1'b0;
                        end
                    end
                    ST_BIT_LO: begin
                        lines.scl <= 1'b1;
                        state     <= ST_BIT_HI;
                    end
                    ST_BIT_HI: begin
                        lines.scl <= 1'b0;
                        if (bit_idx < IDX_W'(ACK_SLOT)) begin
                            bit_idx <= bit_idx + 1'b1;
                            state   <= ST_BIT_LO;
                            if (bit_idx + 1'b1 < IDX_W'(ACK_SLOT)) begin
                                lines.sda <= is_rd ? 1'b1 : sh_q[6];
                            end else begin
                                lines.sda <= is_rd ? ack_lvl : 1'b1;
                            end
                        end else begin
                            ack_hold <= sda_in;
                            state    <= ST_TAIL;
                        end
                    end
                    ST_TAIL: begin
                        lines.sda <= 1'b1;
                        rdata     <= sh_q;
                        ack_n     <= ack_hold;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign scl_oe    = ~lines.scl;
    assign sda_oe    = ~lines.sda;

endmodule

// File: rtl/i2c_prim_master_chk.sv
module i2c_prim_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [2:0] cmd_code,
    input logic       cmd_ready,
    input logic       done,
    input logic       bus_busy,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       in_byte
);
    AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (in_byte && !scl_oe && !$past(scl_oe)) |-> (sda_oe == $past(sda_oe))) else $error("sda moved while scl high"); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done wider than one cycle"); // R10

    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready) else $error("done without ready"); // R10

    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_code <= 3'd4) |=> !cmd_ready) else $error("ready stayed high after accept"); // R9

    AST_START_OWNS_BUS: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && sda_oe && !$past(sda_oe)) |-> bus_busy) else $error("start edge without busy"); // R11

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> (!scl_oe && !sda_oe && done)) else $error("busy dropped with lines held"); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && $past(cmd_ready) && !$past(cmd_valid && cmd_code <= 3'd4))
        |-> ($stable(scl_oe) && $stable(sda_oe))) else $error("lines moved while idle"); // R12
endmodule

bind i2c_prim_master i2c_prim_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_ready (cmd_ready),
    .done      (done),
    .bus_busy  (bus_busy),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .in_byte   (in_byte)
);

// File: tb/i2c_prim_master_tb.sv
module i2c_prim_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [7:0] cmd_wdata = 8'd0;
    logic       sda_in = 1'b1;
    logic       cmd_ready, done, ack_n, bus_busy, scl_oe, sda_oe;
    logic [7:0] rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_prim_master #(.HALF_CLKS(H)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .done(done), .rdata(rdata),
        .ack_n(ack_n), .bus_busy(bus_busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_in(sda_in)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- slave model ----------------
    int         s_kind = 0;      // 0 none, 1 write target, 2 read source
    logic [7:0] s_byte = 8'h00;
    logic       s_ack  = 1'b0;
    int         epoch = 0, seen = 0, nfall = 0;
    logic       prev_scl = 1'b1;

    always @(negedge clk) begin
        logic drv;
        if (seen != epoch) begin
            seen  = epoch;
            nfall = 0;
        end
        if (prev_scl && scl_oe) nfall++;
        prev_scl = !scl_oe;
        drv = 1'b1;
        if (s_kind == 2 && nfall < 8) drv = s_byte[7-nfall];
        if (s_kind == 1 && nfall == 8) drv = s_ack;
        sda_in = !sda_oe && drv;
    end

    // ---------------- reference model ----------------
    logic [1:0] q[$];
    logic       pend = 1'b0;
    logic [1:0] fin = 2'b11, cur = 2'b11;
    logic       e_done = 1'b0, e_busy = 1'b0, e_ack = 1'b1, n_ack = 1'b1;
    logic [7:0] e_rdata = 8'h00, n_rdata = 8'h00;
    int         cur_op = -1;

    task automatic seg(input logic c, input logic d, input int n);
        for (int i = 0; i < n; i++) q.push_back({c, d});
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); pend = 0; cur = 2'b11; e_done = 0; e_busy = 0;
            e_rdata = 0; e_ack = 1; cur_op = -1;
        end else begin
            e_done = 0;
            if (q.size() == 0 && !pend && cmd_valid && cmd_code <= 3'd4) begin
                cur_op = int'(cmd_code);
                epoch++;
                case (cmd_code)
                    3'd0: begin seg(1,1,2*H); seg(1,0,2*H); seg(0,0,2*H); fin = 2'b00; e_busy = 1; end
                    3'd1: begin seg(0,0,H); seg(1,0,2*H); seg(1,1,2*H); fin = 2'b11; end
                    3'd2: begin
                        for (int i = 7; i >= 0; i--) begin seg(0,cmd_wdata[i],H); seg(1,cmd_wdata[i],H); end
                        seg(0,1,H); seg(1,1,H); seg(0,1,H); fin = 2'b01;
                        n_rdata = cmd_wdata; n_ack = s_ack;
                    end
                    default: begin
                        logic a;
                        a = (cmd_code == 3'd4);
                        for (int i = 0; i < 8; i++) begin seg(0,1,H); seg(1,1,H); end
                        seg(0,a,H); seg(1,a,H); seg(0,a,H); fin = 2'b01;
                        n_rdata = s_byte; n_ack = a;
                    end
                endcase
                pend = 1;
            end
            if (q.size() > 0) cur = q.pop_front();
            else if (pend) begin
                pend = 0; cur = fin; e_done = 1;
                if (cur_op == 1) e_busy = 0;
                if (cur_op >= 2) begin e_rdata = n_rdata; e_ack = n_ack; end
            end
        end
    end

    function automatic string op_tag(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3, 4: return "R7";
            default: return "R12";
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            string lt;
            lt = (q.size() > 0 || pend || e_done) ? op_tag(cur_op) : "R12";
            chk(lt, "scl_oe", scl_oe, !cur[1]);
            chk(lt, "sda_oe", sda_oe, !cur[0]);
            chk("R9",  "cmd_ready", cmd_ready, (q.size() == 0 && !pend));
            chk("R10", "done", done, e_done);
            chk("R11", "bus_busy", bus_busy, e_busy);
            chk(e_done ? ((cur_op == 2) ? "R6" : "R7") : "R10", "rdata", rdata, e_rdata);
            chk(e_done ? ((cur_op == 2) ? "R6" : "R8") : "R10", "ack_n", ack_n, e_ack);
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic run(input logic [2:0] code, input logic [7:0] wd,
                       input int kind, input logic [7:0] sb, input logic sa);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        s_kind = kind; s_byte = sb; s_ack = sa;
        cmd_wdata = wd; cmd_code = code; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset scl_oe", scl_oe, 0);
        chk("R1", "reset sda_oe", sda_oe, 0);
        chk("R1", "reset ready", cmd_ready, 1);
        chk("R1", "reset busy", bus_busy, 0);
        chk("R1", "reset done", done, 0);

        // unknown codes
        cmd_valid = 1'b1; cmd_code = 3'd5;
        @(negedge clk); cmd_code = 3'd7;
        @(negedge clk); cmd_code = 3'd6;
        @(negedge clk); cmd_valid = 1'b0;
        chk("R2", "ready after unknown", cmd_ready, 1);
        chk("R2", "scl after unknown", scl_oe, 0);
        chk("R2", "sda after unknown", sda_oe, 0);

        run(3'd0, 8'h00, 0, 8'h00, 1'b1);
        chk("R11", "busy after start", bus_busy, 1);
        run(3'd2, 8'hA5, 1, 8'h00, 1'b0);
        chk("R6", "write ack", ack_n, 0);
        chk("R6", "write echo", rdata, 8'hA5);

        // write with NACK while a stop is held on the command inputs
        @(negedge clk);
        s_kind = 1; s_ack = 1'b1; cmd_wdata = 8'h3C; cmd_code = 3'd2; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_code = 3'd1;
        repeat (10) @(negedge clk);
        chk("R9", "ready while busy", cmd_ready, 0);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        chk("R6", "write nack", ack_n, 1);
        repeat (6) @(negedge clk);
        chk("R9", "held stop dropped busy", bus_busy, 1);
        chk("R9", "held stop dropped scl", scl_oe, 1);

        run(3'd3, 8'h00, 2, 8'h96, 1'b0);
        chk("R7", "read byte", rdata, 8'h96);
        chk("R8", "read ack", ack_n, 0);
        run(3'd4, 8'h00, 2, 8'h5B, 1'b0);
        chk("R7", "read byte 2", rdata, 8'h5B);
        chk("R8", "read nack", ack_n, 1);
        run(3'd1, 8'h00, 0, 8'h00, 1'b1);
        chk("R11", "busy after stop", bus_busy, 0);
        chk("R4", "scl released", scl_oe, 0);
        chk("R4", "sda released", sda_oe, 0);

        run(3'd0, 8'h00, 0, 8'h00, 1'b1);
        run(3'd2, 8'h00, 1, 8'h00, 1'b0);
        run(3'd0, 8'h00, 0, 8'h00, 1'b1);
        chk("R11", "busy after repeated start", bus_busy, 1);
        chk("R10", "start keeps rdata", rdata, 8'h00);
        run(3'd4, 8'h00, 2, 8'hFF, 1'b0);
        chk("R7", "read all ones", rdata, 8'hFF);
        run(3'd2, 8'hFF, 1, 8'h00, 1'b0);
        chk("R6", "write ones ack", ack_n, 0);
        run(3'd1, 8'h00, 0, 8'h00, 1'b1);
        repeat (5) @(negedge clk);
        chk("R12", "idle scl", scl_oe, 0);
        chk("R12", "idle sda", sda_oe, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule